// File: doc/BRIEF.md
# Zero-Suppressing Column Readout Sequencer

This block is the end-of-column controller for one double column of a pixel matrix. The two columns of the pair share their digital logic, so the double column forms a single serial chain. Columns are read one after another through a token. When this controller receives the token, it enables the shift of its own chain, which stands in for the gated readout clock. It then streams the column's content onto one serial output line. When it finishes, it hands the token to the next column.

Pixels are grouped into super-pixels of 2 x 8 (16 consecutive chain positions). With compression enabled, the controller skips an empty column, an empty super-pixel or an unhit pixel, using the per-pixel hit flags. With compression disabled, it reads out the full frame. Three counters follow the position in the column: a bit counter inside a pixel word, a pixel counter inside a super-pixel and a cluster counter over the super-pixels. Together they tell the controller when the column is finished. The controller of the last column also raises a done pulse for the periphery.

Top module: `zs_col_readout`

## Requirements
- R1: While reset is active and right after it, `ser_valid`, `col_shift_en`, `tok_out` and `done` are all 0.
- R2: Without a `tok_in` pulse the block stays idle and emits nothing. The first output bit appears in the cycle after the clock edge that samples `tok_in`.
- R3: With `compress_en` = 0 (sampled together with the token), the stream is exactly NPIX*DBITS data bits, pixel 0 first, with no flag bits. Each data bit is taken from `pix_bit_in` in a cycle where `col_shift_en` = 1.
- R4: With compression, a column that holds any hit starts with a 1 bit. After it come the super-pixels in ascending order, each led by a flag that is the OR of the hit flags of pixels s*16 to s*16+15 (`hit_flags` bit p belongs to chain pixel p).
- R5: A super-pixel whose flag is 0 contributes only that single 0 bit.
- R6: For a super-pixel whose flag is 1, each of its 16 pixels emits its hit flag bit, and a hit pixel then emits DBITS data bits. `col_shift_en` is 1 only during data bits.
- R7: With compression, a column without any hit emits one 0 bit, and `tok_out` rises in the very next cycle.
- R8: `tok_out` is a one-cycle pulse in the cycle right after the last emitted bit. The block is then idle again.
- R9: `done` pulses together with `tok_out` if `last_col` = 1, and stays 0 otherwise.
- R10: A `tok_in` pulse that arrives during a readout is ignored. The stream is unchanged and no second readout follows.
- R11: The bit counter never goes beyond DBITS-1, and the counters receive at most one step command per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in | input | 1 | Start token from the previous column |
| compress_en | input | 1 | 1 = zero-suppressed readout, 0 = full frame |
| last_col | input | 1 | This controller serves the final column |
| hit_flags | input | 2*ROWS (32) | Hit flag per chain pixel, bit p = pixel p |
| pix_bit_in | input | 1 | Current head bit of the column shift chain |
| col_shift_en | output | 1 | Shift enable of the column chain (gated clock) |
| ser_out | output | 1 | Serial readout data |
| ser_valid | output | 1 | ser_out carries a bit this cycle |
| tok_out | output | 1 | Start token to the next column |
| done | output | 1 | Whole-matrix readout finished |

## Verification
The hardest situation to reach from the ports is a stray token during a long readout. The second `tok_in` must leave the stream untouched, and it must not restart the column after the token is passed on. The bench replays a fully hit compressed column and pulses `tok_in` twenty cycles into the stream. It then compares the whole stream and watches the idle cycles that follow `tok_out`. Super-pixel boundaries are reached with hit patterns that put hits only in the last pixel of each group, and with one group empty while the other is dense.

// File: rtl/zs_rd_pkg.sv
package zs_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLF,
      ST_SPF,
      ST_PXF,
      ST_DATA,
      ST_PASS
   } rd_state_e;
endpackage

// File: rtl/zs_hit_map.sv
module zs_hit_map #(
   parameter int NPIX    = 32,
   parameter int SP_SIZE = 16,
   localparam int NSP    = NPIX / SP_SIZE
) (
   input  logic [NPIX-1:0] hit_flags,
   output logic [NSP-1:0]  sp_hit,
   output logic            col_hit
);
   for (genvar s = 0; s < NSP; s++) begin : g_sp
      assign sp_hit[s] = |hit_flags[s*SP_SIZE +: SP_SIZE];
   end
   assign col_hit = |sp_hit;
endmodule

// File: rtl/zs_pos_cnt.sv
module zs_pos_cnt #(
   parameter int DBITS   = 8,
   parameter int SP_SIZE = 16,
   parameter int NSP     = 2,
   localparam int BW     = $clog2(DBITS),
   localparam int PW     = $clog2(SP_SIZE),
   localparam int SW     = $clog2(NSP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          bit_step,
   input  logic          pix_step,
   input  logic          sp_step,
   output logic [BW-1:0] bit_cnt,
   output logic [PW-1:0] pix_cnt,
   output logic [SW-1:0] sp_cnt,
   output logic          bit_last,
   output logic          pix_last,
   output logic          sp_last
);
   assign bit_last = (bit_cnt == BW'(DBITS-1));
   assign pix_last = (pix_cnt == PW'(SP_SIZE-1));
   assign sp_last  = (sp_cnt  == SW'(NSP-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         pix_cnt <= '0;
         sp_cnt  <= '0;
      end else if (clr) begin
         bit_cnt <= '0;
         pix_cnt <= '0;
         sp_cnt  <= '0;
      end else if (sp_step) begin
         bit_cnt <= '0;
         pix_cnt <= '0;
         sp_cnt  <= sp_cnt + 1'b1;
      end else if (pix_step) begin
         bit_cnt <= '0;
         pix_cnt <= pix_cnt + 1'b1;
         if (pix_last) sp_cnt <= sp_cnt + 1'b1;
      end else if (bit_step) begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   a_r11_bit_range : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= BW'(DBITS-1));
   a_r11_one_step : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clr, bit_step, pix_step, sp_step}));
endmodule

// File: rtl/zs_col_readout.sv
module zs_col_readout
   import zs_rd_pkg::*;
#(
   parameter int ROWS  = 16,
   parameter int SP_W  = 2,
   parameter int SP_H  = 8,
   parameter int DBITS = 8,
   localparam int NPIX    = 2 * ROWS,
   localparam int SP_SIZE = SP_W * SP_H,
   localparam int NSP     = NPIX / SP_SIZE,
   localparam int BW      = $clog2(DBITS),
   localparam int PW      = $clog2(SP_SIZE),
   localparam int SW      = $clog2(NSP)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tok_in,
   input  logic            compress_en,
   input  logic            last_col,
   input  logic [NPIX-1:0] hit_flags,
   input  logic            pix_bit_in,
   output logic            col_shift_en,
   output logic            ser_out,
   output logic            ser_valid,
   output logic            tok_out,
   output logic            done
);
   if (ROWS % SP_H != 0) begin : g_bad_rows
      $error("ROWS must be a multiple of SP_H");
   end
   if (SP_W != 2) begin : g_bad_spw
      $error("a double column needs SP_W = 2");
   end
   if (DBITS < 2) begin : g_bad_dbits
      $error("DBITS must be at least 2");
   end
   if ((NSP < 2) || ((NSP & (NSP-1)) != 0) || ((SP_SIZE & (SP_SIZE-1)) != 0)) begin : g_bad_nsp
      $error("super-pixel count and size must be powers of two, count >= 2");
   end

   rd_state_e state, nxt;
   logic mode_q;

   logic [NSP-1:0] sp_hit;
   logic           col_hit;
   logic [BW-1:0]  bit_cnt;
   logic [PW-1:0]  pix_cnt;
   logic [SW-1:0]  sp_cnt;
   logic           bit_last, pix_last, sp_last;
   logic           clr, bit_step, pix_step, sp_step;
   logic           cur_hit;

   zs_hit_map #(.NPIX(NPIX), .SP_SIZE(SP_SIZE)) u_map (
      .hit_flags (hit_flags),
      .sp_hit    (sp_hit),
      .col_hit   (col_hit)
   );

   zs_pos_cnt #(.DBITS(DBITS), .SP_SIZE(SP_SIZE), .NSP(NSP)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .bit_step (bit_step),
      .pix_step (pix_step),
      .sp_step  (sp_step),
      .bit_cnt  (bit_cnt),
      .pix_cnt  (pix_cnt),
      .sp_cnt   (sp_cnt),
      .bit_last (bit_last),
      .pix_last (pix_last),
      .sp_last  (sp_last)
   );

   assign cur_hit = hit_flags[{sp_cnt, pix_cnt}];

   always_comb begin
      nxt          = state;
      clr          = 1'b0;
      bit_step     = 1'b0;
      pix_step     = 1'b0;
      sp_step      = 1'b0;
      ser_valid    = 1'b0;
      ser_out      = 1'b0;
      col_shift_en = 1'b0;
      tok_out      = 1'b0;
      done         = 1'b0;
      unique case (state)
         ST_IDLE: begin
            clr = 1'b1;
            if (tok_in) nxt = compress_en ? ST_COLF : ST_DATA;
         end
         ST_COLF: begin
            ser_valid = 1'b1;
            ser_out   = col_hit;
            nxt       = col_hit ? ST_SPF : ST_PASS;
         end
         ST_SPF: begin
            ser_valid = 1'b1;
            ser_out   = sp_hit[sp_cnt];
            if (sp_hit[sp_cnt]) begin
               nxt = ST_PXF;
            end else begin
               sp_step = 1'b1;
               nxt     = sp_last ? ST_PASS : ST_SPF;
            end
         end
         ST_PXF: begin
            ser_valid = 1'b1;
            ser_out   = cur_hit;
            if (cur_hit) begin
               nxt = ST_DATA;
            end else begin
               pix_step = 1'b1;
               nxt      = pix_last ? (sp_last ? ST_PASS : ST_SPF) : ST_PXF;
            end
         end
         ST_DATA: begin
            ser_valid    = 1'b1;
            ser_out      = pix_bit_in;
            col_shift_en = 1'b1;
            if (!bit_last) begin
               bit_step = 1'b1;
            end else begin
               pix_step = 1'b1;
               if (mode_q)
                  nxt = pix_last ? (sp_last ? ST_PASS : ST_SPF) : ST_PXF;
               else
                  nxt = (pix_last && sp_last) ? ST_PASS : ST_DATA;
            end
         end
         ST_PASS: begin
            tok_out = 1'b1;
            done    = last_col;
            nxt     = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && tok_in) mode_q <= compress_en;
      end
   end

   a_r7_empty_pass : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COLF && !col_hit) |=> tok_out);
   a_r8_tok_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |=> !tok_out && !ser_valid);
   a_r6_shift_emits : assert property (@(posedge clk) disable iff (!rst_n)
      col_shift_en |-> ser_valid && !tok_out);
   a_r9_done_with_tok : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> tok_out && last_col);
   a_r5_sp_skip : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SPF && !sp_hit[sp_cnt]) |=> !col_shift_en && state != ST_PXF);
   a_r10_busy_stays : assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_PASS) |=> state != ST_IDLE);
endmodule

// File: tb/tb_zs_col_readout.sv
module tb_zs_col_readout;
   localparam int ROWS = 16;
   localparam int NPIX = 2 * ROWS;
   localparam int DB   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tok_in = 1'b0, comp_r = 1'b0, last_r = 1'b0;
   logic [NPIX-1:0] hits_r = '0;
   logic pix_bit_in, col_shift_en, ser_out, ser_valid, tok_out, done;
   logic chain_rst = 1'b1;
   int   sh_n;

   int total = 0, failed = 0;
   logic exp_bits [0:511];
   int exp_n, exp_shifts;

   always #2 clk = ~clk;

   zs_col_readout #(.ROWS(ROWS), .DBITS(DB)) dut (
      .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .compress_en(comp_r),
      .last_col(last_r), .hit_flags(hits_r), .pix_bit_in(pix_bit_in),
      .col_shift_en(col_shift_en), .ser_out(ser_out), .ser_valid(ser_valid),
      .tok_out(tok_out), .done(done)
   );

   function automatic logic [7:0] pix_byte(int p);
      return 8'((p * 37 + 5) & 255);
   endfunction

   // chain model: unhit pixels bypass themselves when compressing
   function automatic logic bit_at(int n, logic [NPIX-1:0] h, logic c);
      int k = n / DB;
      int seen = 0;
      for (int p = 0; p < NPIX; p++) begin
         if (!c || h[p]) begin
            if (seen == k) return pix_byte(p)[DB-1-(n % DB)];
            seen++;
         end
      end
      return 1'b0;
   endfunction

   assign pix_bit_in = bit_at(sh_n, hits_r, comp_r);

   always @(posedge clk) begin
      if (chain_rst) sh_n <= 0;
      else if (col_shift_en) sh_n <= sh_n + 1;
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic push(input logic b);
      exp_bits[exp_n] = b;
      exp_n++;
   endtask

   task automatic build_exp(input logic c, input logic [NPIX-1:0] h);
      exp_n = 0; exp_shifts = 0;
      if (!c) begin
         for (int p = 0; p < NPIX; p++)
            for (int b = 0; b < DB; b++) begin push(pix_byte(p)[DB-1-b]); exp_shifts++; end
      end else if (h == '0) begin
         push(1'b0);
      end else begin
         push(1'b1);
         for (int s = 0; s < NPIX/16; s++) begin
            push(|h[s*16 +: 16]);
            if (|h[s*16 +: 16])
               for (int k = 0; k < 16; k++) begin
                  push(h[s*16+k]);
                  if (h[s*16+k])
                     for (int b = 0; b < DB; b++) begin
                        push(pix_byte(s*16+k)[DB-1-b]); exp_shifts++;
                     end
               end
         end
      end
   endtask

   task automatic run_vec(input logic c, input logic l, input logic [NPIX-1:0] h,
                          input int poke);
      int got = 0, mism = -1, shifts = 0, lastv = -1, tcyc = -1, cyc = 0;
      logic dn = 1'b0, bad_idle = 1'b0;
      string rq;
      @(negedge clk);
      hits_r = h; comp_r = c; last_r = l; chain_rst = 1'b1;
      build_exp(c, h);
      @(negedge clk);
      chain_rst = 1'b0; tok_in = 1'b1;
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         tok_in = (cyc == poke);
         if (ser_valid) begin
            if (mism < 0 && (got >= exp_n || ser_out !== exp_bits[got])) mism = got;
            got++; lastv = cyc;
         end
         if (col_shift_en) shifts++;
         if (tok_out) begin tcyc = cyc; dn = done; break; end
         cyc++;
      end
      tok_in = 1'b0;
      rq = !c ? "R3" : (h == '0 ? "R7" : "R4/R5/R6");
      chk(mism < 0, rq, "first mismatching bit index", mism, -1);
      chk(got == exp_n, rq, "stream length", got, exp_n);
      chk(shifts == exp_shifts, "R6", "shift enable count", shifts, exp_shifts);
      chk(tcyc >= 0 && tcyc == lastv + 1, (h == '0 && c) ? "R7" : "R8",
          "token cycle vs last bit", tcyc, lastv + 1);
      chk(dn == l, "R9", "done with token", int'(dn), int'(l));
      @(negedge clk);
      chk(!tok_out, "R8", "token pulse width", int'(tok_out), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (ser_valid || tok_out) bad_idle = 1'b1;
      end
      chk(!bad_idle, poke >= 0 ? "R10" : "R8", "idle after token", int'(bad_idle), 0);
   endtask

   // {compress, last, hits}
   localparam logic [NPIX+1:0] VEC [8] = '{
      {1'b0, 1'b0, 32'h0000_0000},
      {1'b0, 1'b1, 32'h8001_0010},
      {1'b1, 1'b0, 32'h0000_0000},
      {1'b1, 1'b1, 32'h0000_0001},
      {1'b1, 1'b0, 32'hFFFF_FFFF},
      {1'b1, 1'b1, 32'hA5A5_0000},
      {1'b1, 1'b0, 32'h8000_8000},
      {1'b1, 1'b1, 32'h0001_0000}
   };

   initial begin
      repeat (100000) @(posedge clk);
      failed++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      logic seen;
      repeat (3) @(negedge clk);
      chk(!ser_valid && !col_shift_en && !tok_out && !done, "R1", "outputs in reset",
          int'({ser_valid, col_shift_en, tok_out, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ser_valid && !col_shift_en && !tok_out && !done, "R1", "outputs after reset",
          int'({ser_valid, col_shift_en, tok_out, done}), 0);
      seen = 1'b0;
      comp_r = 1'b1; hits_r = '1;
      repeat (10) begin
         @(negedge clk);
         if (ser_valid || tok_out || col_shift_en) seen = 1'b1;
      end
      chk(!seen, "R2", "activity without token", int'(seen), 0);
      foreach (VEC[i])
         run_vec(VEC[i][NPIX+1], VEC[i][NPIX], VEC[i][NPIX-1:0], -1);
      // stray token mid-stream on a dense column
      run_vec(1'b1, 1'b0, 32'hFFFF_FFFF, 20);
      // stray token mid-stream in full-frame mode
      run_vec(1'b0, 1'b0, 32'h0000_0F00, 100);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule